// File: doc/BRIEF.md
# Wake-Up Event Status Register

This block holds the 32-bit status word that a power management controller uses to record why the system should wake. It watches eight wake sources: general-purpose I/O, the PCI power-management-event input, USB, two Ethernet controllers, a timer, and two external interrupt lines. Each source has a sticky flag. A flag can be set only while that source's mask bit is 1. A summary flag records that at least one unmasked event was captured, which means the device should leave its low-power state. Software clears any flag by writing 1 to its position.

From these flags the block drives two outputs: an interrupt request to the processor core and a power-management-event line to an external host. The GPIO and USB flags go to one of these two outputs, chosen by a global PME-enable input. All other flags can reach only the core interrupt. The mask and control bits arrive as inputs. The register is read and written through a single-cycle port. Bit numbering is big-endian, so bit 0 is the MSB (vector index 31) and bit 31 is the LSB (vector index 0).

Top module: `wk_event_ctl`

## Requirements
- R1: While reset is held, and after it is released, `acc_rdata` reads 0 and both `core_irq` and `pme_out` are 0.
- R2: Bits 0–22 (vector [31:9]) always read 0. Writing 1 to them changes no other bit.
- R3: An event on `wake_ev[i]` while `wake_mask[i]` is 1 sets source flag i at big-endian bit 23+i (vector index 8−i) at the next clock edge. Source order for i = 0..7: GPIO, PCI PME, USB, Ethernet 1, Ethernet 2, timer, external interrupt 1, external interrupt 2.
- R4: An event whose mask bit is 0 leaves its flag and the summary flag unchanged.
- R5: A write with 1 at a flag's position clears that flag at the next edge. A write with 0 leaves it unchanged.
- R6: If a captured event and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R7: The summary flag at big-endian bit 31 (vector index 0) is set by any captured event. It is cleared by writing 1 to it.
- R8: `core_irq` = `irq_en` AND summary AND (at least one core-routed flag). PCI, Ethernet 1/2, timer and both external interrupts are always core-routed. GPIO and USB are core-routed only when `pme_en` is 0.
- R9: `pme_out` is the OR of the GPIO and USB flags when `pme_en` is 1, and is 0 when `pme_en` is 0. The PCI flag never drives it.
- R10: Flags stay set after their event input drops, until they are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wake_ev | input | 8 | Per-source wake event, already synchronous to clk |
| wake_mask | input | 8 | Per-source capture enable |
| pme_en | input | 1 | Routes GPIO/USB to the external event line when 1 |
| irq_en | input | 1 | Core interrupt enable |
| acc_wr | input | 1 | Write strobe, one cycle |
| acc_wdata | input | 32 | Write data, 1 clears the flag at that position |
| acc_rdata | output | 32 | Current register contents |
| core_irq | output | 1 | Interrupt request to the processor core |
| pme_out | output | 1 | Power-management event to the remote host |

## Verification
A flag held in the wrong state shows on `acc_rdata` and, through the routing logic, on `core_irq` or `pme_out` in the cycle right after the edge that stored it. The outputs have no pipeline between the flags and the ports. Swapping the GPIO/USB routing would change which output rises under the same flag pattern. A lost set-versus-clear race would leave a bit at 0 where 1 is expected. A wrong bit order would move a flag to a neighbouring source's position, which the stimulus table catches because it fires sources one at a time and in groups.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int NSRC     = 8;
  localparam int WORD     = 32;
  localparam int FIRST_BE = 23;               // big-endian position of source 0
  localparam int SUM_BE   = FIRST_BE + NSRC;  // big-endian position of summary
  localparam int SUM_IDX  = WORD - 1 - SUM_BE;

  typedef enum int {
    SRC_GPIO = 0, SRC_PCI = 1, SRC_USB = 2, SRC_ETH1 = 3,
    SRC_ETH2 = 4, SRC_TMR = 5, SRC_INT1 = 6, SRC_INT2 = 7
  } wk_src_e;

  // sources that follow the PME-enable routing choice
  localparam logic [NSRC-1:0] SWITCHABLE =
    (NSRC'(1) << SRC_GPIO) | (NSRC'(1) << SRC_USB);

  function automatic int src_idx(input int s);
    return WORD - 1 - (FIRST_BE + s);
  endfunction
endpackage

// File: rtl/wk_rst_sync.sv
module wk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/wk_flag_bank.sv
module wk_flag_bank
  import wk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev,
  input  logic [NSRC-1:0] mask,
  input  logic [NSRC-1:0] clr_src,
  input  logic            clr_sum,
  output logic [NSRC-1:0] flag_q,
  output logic            sum_q
);
  logic [NSRC-1:0] set_src;
  logic            set_sum;
  logic            sum_d;
  logic            sum_ce;

  assign set_src = ev & mask;
  assign set_sum = |set_src;

  for (genvar i = 0; i < NSRC; i++) begin : g_cell
    logic cell_d;
    logic cell_ce;

    always_comb begin
      cell_ce = set_src[i] | clr_src[i];
      cell_d  = set_src[i];            // set wins over clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q[i] <= 1'b0;
      else if (cell_ce) flag_q[i] <= cell_d;
    end

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set_src[i] |=> flag_q[i]);
    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_src[i] && !set_src[i]) |=> !flag_q[i]);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_src[i] && !clr_src[i]) |=> $stable(flag_q[i]));
  end

  always_comb begin
    sum_ce = set_sum | clr_sum;
    sum_d  = set_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= 1'b0;
    else if (sum_ce) sum_q <= sum_d;
  end

  p_summary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_sum |=> sum_q);
endmodule

// File: rtl/wk_route.sv
module wk_route
  import wk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] flag_q,
  input  logic            sum_q,
  input  logic            pme_en,
  input  logic            irq_en,
  output logic            core_irq,
  output logic            pme_out
);
  logic [NSRC-1:0] core_route;
  logic [NSRC-1:0] host_route;

  always_comb begin
    core_route = pme_en ? ~SWITCHABLE : '1;
    host_route = pme_en ?  SWITCHABLE : '0;
    core_irq   = irq_en & sum_q & (|(flag_q & core_route));
    pme_out    = |(flag_q & host_route);
  end

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq |-> (irq_en && sum_q));
  p_pme_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pme_out |-> pme_en);
  p_pci_core_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q == (NSRC'(1) << SRC_PCI)) |-> !pme_out);
endmodule

// File: rtl/wk_event_ctl.sv
module wk_event_ctl
  import wk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] wake_ev,
  input  logic [NSRC-1:0] wake_mask,
  input  logic            pme_en,
  input  logic            irq_en,
  input  logic            acc_wr,
  input  logic [WORD-1:0] acc_wdata,
  output logic [WORD-1:0] acc_rdata,
  output logic            core_irq,
  output logic            pme_out
);
  logic            srst_n;
  logic [NSRC-1:0] clr_src;
  logic            clr_sum;
  logic [NSRC-1:0] flag_q;
  logic            sum_q;

  wk_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_sync(srst_n)
  );

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      clr_src[i] = acc_wr & acc_wdata[src_idx(i)];
    clr_sum = acc_wr & acc_wdata[SUM_IDX];
  end

  wk_flag_bank u_bank (
    .clk(clk), .rst_n(srst_n), .ev(wake_ev), .mask(wake_mask),
    .clr_src(clr_src), .clr_sum(clr_sum), .flag_q(flag_q), .sum_q(sum_q)
  );

  wk_route u_route (
    .clk(clk), .rst_n(srst_n), .flag_q(flag_q), .sum_q(sum_q),
    .pme_en(pme_en), .irq_en(irq_en), .core_irq(core_irq), .pme_out(pme_out)
  );

  always_comb begin
    acc_rdata = '0;
    for (int i = 0; i < NSRC; i++)
      acc_rdata[src_idx(i)] = flag_q[i];
    acc_rdata[SUM_IDX] = sum_q;
  end

  p_sticky_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (!acc_wr && acc_rdata[src_idx(SRC_TMR)]) |=> acc_rdata[src_idx(SRC_TMR)]);
endmodule

// File: tb/wk_event_ctl_test.sv
module wk_event_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  wake_ev, wake_mask;
  logic        pme_en, irq_en, acc_wr;
  logic [31:0] acc_wdata, acc_rdata;
  logic        core_irq, pme_out;
  int          total = 0, bad = 0;

  always #2 clk = ~clk;   // 250 MHz

  wk_event_ctl uut (.*);

  // {ev, mask, wr, wdata[8:0], pme_en, irq_en, exp[8:0], exp_irq, exp_pme}
  // low 9 bits: [8]GPIO [7]PCI [6]USB [5]ETH1 [4]ETH2 [3]TMR [2]INT1 [1]INT2 [0]SUM
  localparam int NV = 13;
  localparam logic [38:0] VEC [NV] = '{
    {8'h01, 8'hFF, 1'b0, 9'h000, 1'b0, 1'b1, 9'h101, 1'b1, 1'b0},  // R3 GPIO to core
    {8'h00, 8'hFF, 1'b0, 9'h000, 1'b1, 1'b1, 9'h101, 1'b0, 1'b1},  // R9 GPIO to host, R10
    {8'h02, 8'hFF, 1'b0, 9'h000, 1'b1, 1'b1, 9'h181, 1'b1, 1'b1},  // R8 PCI core only
    {8'h00, 8'hFF, 1'b1, 9'h100, 1'b1, 1'b1, 9'h081, 1'b1, 1'b0},  // R5 clear GPIO
    {8'h04, 8'hFB, 1'b0, 9'h000, 1'b1, 1'b1, 9'h081, 1'b1, 1'b0},  // R4 USB masked
    {8'h04, 8'hFF, 1'b0, 9'h000, 1'b1, 1'b0, 9'h0C1, 1'b0, 1'b1},  // R8 irq_en off, R9 USB
    {8'h00, 8'hFF, 1'b1, 9'h000, 1'b1, 1'b0, 9'h0C1, 1'b0, 1'b1},  // R5 write zero
    {8'h80, 8'hFF, 1'b1, 9'h002, 1'b0, 1'b1, 9'h0C3, 1'b1, 1'b0},  // R6 set wins
    {8'h00, 8'hFF, 1'b1, 9'h1FF, 1'b0, 1'b1, 9'h000, 1'b0, 1'b0},  // R5 clear all
    {8'hF8, 8'hFF, 1'b0, 9'h000, 1'b0, 1'b1, 9'h03F, 1'b1, 1'b0},  // R3 group order
    {8'h00, 8'hFF, 1'b1, 9'h03E, 1'b0, 1'b1, 9'h001, 1'b0, 1'b0},  // R8 summary alone
    {8'h00, 8'hFF, 1'b1, 9'h001, 1'b0, 1'b1, 9'h000, 1'b0, 1'b0},  // R7 summary W1C
    {8'hFF, 8'h00, 1'b0, 9'h000, 1'b0, 1'b1, 9'h000, 1'b0, 1'b0}   // R4 all masked
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wake_ev = '0; acc_wr = 1'b0; acc_wdata = '0;
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(); wake_mask = 8'hFF; pme_en = 1'b0; irq_en = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R1 rdata in reset", acc_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R1 rdata", acc_rdata, 32'h0);
    check("R1 irq/pme", {30'h0, core_irq, pme_out}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      wake_ev   = VEC[v][38:31];
      wake_mask = VEC[v][30:23];
      acc_wr    = VEC[v][22];
      acc_wdata = {23'h0, VEC[v][21:13]};
      pme_en    = VEC[v][12];
      irq_en    = VEC[v][11];
      @(posedge clk); #1;
      idle();
      check($sformatf("R3-vec%0d rdata", v), acc_rdata, {23'h0, VEC[v][10:2]});
      check($sformatf("R8/R9 vec%0d outs", v), {30'h0, core_irq, pme_out},
            {30'h0, VEC[v][1], VEC[v][0]});
    end

    // R2: reserved bits read zero and ignore writes
    wake_ev = 8'hFF; wake_mask = 8'hFF;
    @(posedge clk); #1; idle();
    check("R2 all set", acc_rdata, 32'h0000_01FF);
    acc_wr = 1'b1; acc_wdata = 32'hFFFF_FE00;
    @(posedge clk); #1; idle();
    check("R2 reserved write", acc_rdata, 32'h0000_01FF);
    repeat (4) @(posedge clk);
    #1 check("R10 held", acc_rdata, 32'h0000_01FF);

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    #1 check("R1 async clear", acc_rdata, 32'h0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R1 after re-reset", {acc_rdata[31:2], core_irq, pme_out}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule